// File: doc/BRIEF.md
# Frame Slot Extractor

This block listens, without ever driving anything, to a 16-bit data bus that carries a repeating frame of sample words. Each frame opens with a 3-byte marker, and one sample slot follows another at one slot per clock. On each clock the block takes one byte of the bus word. It takes the upper byte and the lower byte on alternate clocks, and it shifts that byte into a three-deep byte pipeline. When the three pipeline bytes equal the programmed marker, the block has found the start of a frame.

A detected marker clears a slot counter, which then advances once per clock. When the count reaches the slot number chosen by the user, the block raises a one-clock load strobe toward a DAC and hands over the bus word that belongs to that slot. The output word then holds until the next strobe. The slot number is captured at each marker, so a new selection takes effect at the next frame boundary and never in the middle of a frame.

Top module: `frame_slot_extractor`

## Requirements
- R1: While reset is held, and right after it, `dac_load` is 0 and `dac_word` is 0.
- R2: The first clock edge after reset release samples `bus_data[15:8]`. The sampled half then alternates on every edge (lower, upper, lower, ...). The half that is not sampled never affects detection.
- R3: A marker is detected at an edge when the byte sampled at that edge equals `marker_bytes[7:0]`, the byte sampled one edge earlier equals `marker_bytes[15:8]`, and the byte sampled two edges earlier equals `marker_bytes[23:16]`.
- R4: If a marker is detected at edge k, the slot count is 0 after edge k+1 and rises by one per edge after that. `dac_load` is 1 after edge k+2+S, where S is the slot number in force for that frame.
- R5: When `dac_load` is 1, `dac_word` equals the `bus_data` value sampled at the edge just before the strobe edge.
- R6: `dac_load` is high for exactly one clock per detected marker and is never high without a preceding detection.
- R7: The slot number S for a frame is the `slot_sel` value sampled at the marker's detection edge. Changes to `slot_sel` later in the frame do not move that frame's strobe.
- R8: The slot count is 9 bits and stops at 511 instead of wrapping. Slots 256 to 511 are reachable, and slot 511 strobes once and no more.
- R9: `dac_word` keeps its value on every clock in which `dac_load` is 0.
- R10: A marker detected before the pending strobe restarts the count, and the earlier strobe is dropped.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | 16 | Snooped data bus word |
| marker_bytes | input | 24 | Marker pattern, oldest byte in [23:16] |
| slot_sel | input | 9 | Slot number to extract |
| dac_load | output | 1 | One-clock load strobe for the DAC |
| dac_word | output | 16 | Word handed to the DAC |

## Verification
A detection at edge k depends on the three bytes sampled at edges k-2, k-1 and k. The strobe it produces appears after edge k+2+S and carries the bus word sampled at edge k+1+S. The driver counts edges itself and keeps its own copy of the sampled byte history. From these it computes each expected strobe edge and word, and it pushes them into a queue one edge before they are due. The monitor samples on falling edges. There, any strobe at an edge other than the expected one fails, and so does a missing strobe at the expected edge or any change of the word between strobes.

// File: rtl/fse_pkg.sv
package fse_pkg;
  // Saturating increment: holds at lim once reached.
  function automatic int unsigned sat_step(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction
endpackage

// File: rtl/fse_byte_matcher.sv
module fse_byte_matcher #(
  parameter int DW  = 16,
  parameter int BW  = 8,
  parameter int NST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     bus_data,
  input  logic [NST*BW-1:0] marker,
  output logic              match,
  output logic              upper_phase
);
  localparam int HALF = DW / 2;

  function automatic logic [BW-1:0] pick_half(input logic [DW-1:0] w, input logic up);
    return up ? w[DW-1 -: BW] : w[HALF-1 -: BW];
  endfunction

  logic [BW-1:0] stg [NST];
  logic [NST-1:0] eq;

  always_ff @(posedge clk) begin
    if (!rst_n) upper_phase <= 1'b1;
    else        upper_phase <= ~upper_phase;
  end

  // stg[0] holds the newest byte; stg[i] is compared with marker slice i.
  for (genvar i = 0; i < NST; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= pick_half(bus_data, upper_phase);
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
    assign eq[i] = (stg[i] == marker[(i+1)*BW-1 -: BW]);
  end

  assign match = &eq;
endmodule

// File: rtl/fse_slot_counter.sv
module fse_slot_counter #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          match,
  input  logic [CW-1:0] slot_sel,
  output logic          hit,
  output logic [CW-1:0] count,
  output logic          armed
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] slot_q;
  logic [CW-1:0] slot_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q      <= '0;
      slot_active <= '0;
      count       <= CNT_MAX;
      armed       <= 1'b0;
    end else begin
      slot_q <= slot_sel;
      if (match) begin
        slot_active <= slot_q;
        count       <= '0;
        armed       <= 1'b1;
      end else begin
        count <= CW'(fse_pkg::sat_step(32'(count), 32'(CNT_MAX)));
        if (hit) armed <= 1'b0;
      end
    end
  end

  assign hit = armed && (count == slot_active);
endmodule

// File: rtl/fse_word_strobe.sv
module fse_word_strobe #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_data,
  input  logic          hit,
  output logic          dac_load,
  output logic [DW-1:0] dac_word
);
  logic [DW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q   <= '0;
      dac_load <= 1'b0;
      dac_word <= '0;
    end else begin
      word_q   <= bus_data;
      dac_load <= hit;
      if (hit) dac_word <= word_q;
    end
  end
endmodule

// File: rtl/frame_slot_extractor.sv
module frame_slot_extractor #(
  parameter int DW  = 16,
  parameter int BW  = 8,
  parameter int NST = 3,
  parameter int CW  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     bus_data,
  input  logic [NST*BW-1:0] marker_bytes,
  input  logic [CW-1:0]     slot_sel,
  output logic              dac_load,
  output logic [DW-1:0]     dac_word
);
  // Named internal events, observed by the bound checker.
  logic          match_w;
  logic          phase_w;
  logic          hit_w;
  logic          armed_w;
  logic [CW-1:0] count_w;

  fse_byte_matcher #(.DW(DW), .BW(BW), .NST(NST)) u_match (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .marker(marker_bytes),
    .match(match_w), .upper_phase(phase_w)
  );

  fse_slot_counter #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .match(match_w), .slot_sel(slot_sel),
    .hit(hit_w), .count(count_w), .armed(armed_w)
  );

  fse_word_strobe #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .hit(hit_w),
    .dac_load(dac_load), .dac_word(dac_word)
  );
endmodule

// File: rtl/fse_checker.sv
module fse_checker #(
  parameter int DW = 16,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] bus_data,
  input logic          match_w,
  input logic          phase_w,
  input logic          hit_w,
  input logic          armed_w,
  input logic [CW-1:0] count_w,
  input logic          dac_load,
  input logic [DW-1:0] dac_word
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  assert_phase_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_w != $past(phase_w)));

  assert_count_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_w |=> (count_w == '0));

  assert_count_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_w && count_w != CNT_MAX) |=> (count_w == $past(count_w) + 1'b1));

  assert_count_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_w && count_w == CNT_MAX) |=> (count_w == CNT_MAX));

  assert_hit_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w |=> dac_load);

  assert_load_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |-> $past(hit_w));

  assert_hit_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w && !match_w) |=> !armed_w);

  assert_word_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |-> (dac_word == $past(bus_data, 2)));

  assert_word_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_load |-> $stable(dac_word));
endmodule

bind frame_slot_extractor fse_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .match_w(match_w),
  .phase_w(phase_w), .hit_w(hit_w), .armed_w(armed_w), .count_w(count_w),
  .dac_load(dac_load), .dac_word(dac_word)
);

// File: tb/frame_slot_extractor_test.sv
module frame_slot_extractor_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] MARK = 24'hA53CE1;

  typedef struct {
    int unsigned at_edge;
    logic [15:0] word;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_data;
  logic [8:0]  slot_sel;
  logic        dac_load;
  logic [15:0] dac_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_slot_extractor uut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .marker_bytes(MARK),
    .slot_sel(slot_sel), .dac_load(dac_load), .dac_word(dac_word)
  );

  int unsigned ecount = 0;
  always @(posedge clk) ecount <= rst_n ? ecount + 1 : 0;

  int          tests = 0;
  int          fails = 0;
  exp_t        sb[$];
  logic [7:0]  h0 = 8'h00, h1 = 8'h00, h2 = 8'h00;
  bit          pend = 1'b0;
  int unsigned target = 0;
  logic [8:0]  next_slot = 9'd0;
  logic [15:0] last_word = 16'h0000;
  bit          run_mon = 1'b0;

  task automatic note(input bit ok, input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (edge %0d)", req, what, act, exp, ecount);
    end
  endtask

  // Driver: supplies the byte sampled at the next edge and predicts strobes.
  task automatic drive(input logic [7:0] b, input bit wrong_half);
    int unsigned k;
    logic [7:0] sel, unsel;
    logic [15:0] w;
    @(negedge clk);
    k = ecount + 1;
    slot_sel = next_slot;
    sel   = wrong_half ? (8'h10 + 8'(k[3:0])) : b;
    unsel = wrong_half ? b : (k[7:0] ^ 8'h5A);
    w = k[0] ? {sel, unsel} : {unsel, sel};   // odd edges take the upper byte (R2)
    bus_data = w;
    if (pend && k + 1 == target) begin
      sb.push_back('{target, w});
      pend = 1'b0;
    end
    h2 = h1; h1 = h0; h0 = sel;
    if ({h2, h1, h0} == MARK) begin           // R3 detection, R7 slot capture, R10 restart
      pend   = 1'b1;
      target = k + 2 + 32'(slot_sel);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(8'h10 + 8'(i % 16), 1'b0);
  endtask

  task automatic send_marker(input bit wrong_half);
    drive(MARK[23:16], wrong_half);
    drive(MARK[15:8], wrong_half);
    drive(MARK[7:0], wrong_half);
  endtask

  // Monitor: compares strobes with the scoreboard queue.
  always @(negedge clk) begin
    if (run_mon) begin
      if (dac_load) begin
        if (sb.size() == 0) begin
          note(1'b0, "R6", "unexpected strobe (R2 R3 R8)", dac_word, 16'h0000);
        end else if (sb[0].at_edge != ecount) begin
          note(1'b0, "R4", "strobe at wrong edge", 16'(ecount), 16'(sb[0].at_edge));
        end else begin
          note(1'b1, "R4", "strobe timing", 16'(ecount), 16'(sb[0].at_edge));
          note(dac_word == sb[0].word, "R5", "strobe word", dac_word, sb[0].word);
          void'(sb.pop_front());
        end
        last_word = dac_word;
      end else begin
        if (sb.size() != 0 && sb[0].at_edge == ecount) begin
          note(1'b0, "R4", "missing strobe", 16'(ecount), 16'(sb[0].at_edge));
          void'(sb.pop_front());
        end
        note(dac_word == last_word, "R9", "word hold", dac_word, last_word);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_data = 16'h0000;
    slot_sel = 9'd5;
    repeat (3) @(negedge clk);
    note(dac_load == 1'b0, "R1", "load in reset", 16'(dac_load), 16'h0000);
    note(dac_word == 16'h0000, "R1", "word in reset", dac_word, 16'h0000);
    rst_n = 1'b1;
    run_mon = 1'b1;
    @(negedge clk);
    note(dac_load == 1'b0, "R1", "load after reset", 16'(dac_load), 16'h0000);

    next_slot = 9'd5;
    idle(20);                         // R6 no marker, no strobe
    send_marker(1'b0); idle(20);      // R3 R4 R5 slot 5
    next_slot = 9'd0;
    send_marker(1'b0); idle(10);      // R4 slot 0
    next_slot = 9'd300;
    send_marker(1'b0); idle(320);     // R8 slot above 255
    next_slot = 9'd7;
    send_marker(1'b0); idle(3);
    next_slot = 9'd2; idle(20);       // R7 strobe stays at slot 7
    send_marker(1'b0); idle(20);      // R7 slot 2 now active
    next_slot = 9'd9;
    send_marker(1'b0); idle(4);
    send_marker(1'b0); idle(20);      // R10 restart, one strobe only
    send_marker(1'b1); idle(20);      // R2 marker on unsampled half
    idle(1);
    send_marker(1'b0); idle(20);      // R2 marker on opposite parity
    next_slot = 9'd511;
    send_marker(1'b0); idle(540);     // R8 saturation, single strobe
    idle(5);
    note(sb.size() == 0, "R4", "pending strobes left", 16'(sb.size()), 16'h0000);
    run_mon = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule